// File: doc/BRIEF.md
# Fixed-Point Line Scaler Step Generator

This block walks one axis of a video scaler. A line begins when `line_start` is sampled high. At that edge the block captures a step increment, a decimation code, a packed pair of sizes and a start offset. It then produces one output sample per clock for as many clocks as the destination size asks for. Each sample carries an integer source index and a 4-bit sub-pixel phase. A downstream filter uses the index to fetch source pixels and the phase to choose its coefficient set.

Positions are held as fixed-point values with 21 fraction bits. Software loads the increment as ceil(effective_source * 2^21 / destination). For enlargement the effective source is the source size itself. When halving it is half the source size, and when going from half to quarter size it is a quarter of the source size. The block applies the matching power-of-two decimation to the integer part when it forms the source index. A bad configuration sets an error flag, and the block stays silent until a clean line start arrives.

Top module: `line_step_gen`

## Requirements
- R1: After a synchronous reset, `out_valid`, `line_done` and `size_err` are all low.
- R2: After a valid configuration is captured by `line_start` at a clock edge, `out_valid` is high from the next edge onward for exactly the destination size number of consecutive cycles.
- R3: `line_done` is high for a single cycle, in the cycle right after the last valid sample of a completed line, and never together with `out_valid`.
- R4: For sample k (counting from 0), let P = start_ofs * 2^21 + k * step_inc. Then `phase` equals bits 20..17 of P, and the integer part is bits 36..21 of P.
- R5: The decimation code sets the index multiplier: 2'b00 multiplies by 1, 2'b01 by 2 and 2'b10 by 4. `src_index` is (integer part * multiplier) modulo 65536.
- R6: Decimation code 2'b11 is invalid. A `line_start` with it sets `size_err` and produces no samples and no done pulse.
- R7: `size_word` holds the source size in bits 15:0 and the destination size in bits 31:16. If either field is zero at `line_start`, `size_err` goes high and no samples or done pulse appear. `size_err` stays high until a `line_start` with a valid configuration clears it.
- R8: Configuration inputs are sampled only at the `line_start` edge. Changes to them during a line have no effect on that line's samples or length.
- R9: The source index wraps modulo 65536, so a start offset near the top of the range produces indices that roll over to small values.
- R10: A `line_start` during an active line abandons it. The old line produces no further samples and no done pulse, and the new line's first sample follows one edge later.
- R11: A `line_start` sampled in the same cycle in which a completed line's done pulse is being produced does not suppress that pulse. The new line then proceeds normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Starts a line and captures the configuration |
| step_inc | input | 32 | Position increment per output sample, 21 fraction bits |
| dec_code | input | 2 | Decimation code: 00 x1, 01 x2, 10 x4, 11 invalid |
| size_word | input | 32 | Source size [15:0], destination size [31:16] |
| start_ofs | input | 16 | Starting integer source position |
| out_valid | output | 1 | Sample valid |
| src_index | output | 16 | Source index of the current sample |
| phase | output | 4 | Sub-pixel phase of the current sample |
| line_done | output | 1 | One-cycle pulse after a line's last sample |
| size_err | output | 1 | Last captured configuration was invalid |

## Verification
Two events can fall in the same clock: a new line start, and either the final sample or the done pulse of the line in progress. The bench provokes both cases. In one, a restart is raised while samples are still flowing, and the scoreboard expects only the samples emitted before the restart, with no done for the abandoned line. In the other, the restart is timed onto the edge that launches the done pulse, and the scoreboard expects the old line's done to appear followed directly by the complete new line. Any extra sample is caught when it arrives, and any missing sample is caught when the queue is drained.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

  typedef enum logic [1:0] {
    DEC_NONE    = 2'b00,
    DEC_HALF    = 2'b01,
    DEC_QUARTER = 2'b10,
    DEC_BAD     = 2'b11
  } dec_code_e;

  // shift amount applied to the integer position to form the source index
  function automatic logic [1:0] dec_shift(input dec_code_e c);
    case (c)
      DEC_HALF:    dec_shift = 2'd1;
      DEC_QUARTER: dec_shift = 2'd2;
      default:     dec_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/lsg_cfg_check.sv
module lsg_cfg_check
  import lsg_pkg::*;
#(
  parameter int SIZE_W = 16
) (
  input  logic [2*SIZE_W-1:0] size_word,
  input  logic [1:0]          dec_code,
  output logic [SIZE_W-1:0]   dst_size,
  output logic [1:0]          shift,
  output logic                cfg_bad
);

  logic [SIZE_W-1:0] src_size;
  dec_code_e         code;

  always_comb begin
    src_size = size_word[SIZE_W-1:0];
    dst_size = size_word[2*SIZE_W-1:SIZE_W];
    code     = dec_code_e'(dec_code);
    shift    = dec_shift(code);
    cfg_bad  = (src_size == '0) || (dst_size == '0) || (code == DEC_BAD);
  end

endmodule

// File: rtl/lsg_accum.sv
module lsg_accum #(
  parameter int SIZE_W  = 16,
  parameter int FRAC_W  = 21,
  parameter int IDX_W   = 16,
  parameter int INC_W   = 32,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_start,
  input  logic [INC_W-1:0]   step_inc,
  input  logic [IDX_W-1:0]   start_ofs,
  input  logic [SIZE_W-1:0]  dst_size,
  input  logic [1:0]         shift_in,
  input  logic               cfg_bad,
  output logic [IDX_W-1:0]   acc_int,
  output logic [PHASE_W-1:0] acc_ph,
  output logic [1:0]         shift_q,
  output logic               emit,
  output logic               is_last,
  output logic               size_err
);

  localparam int ACC_W = IDX_W + FRAC_W;

  logic [ACC_W-1:0]  acc;
  logic [SIZE_W-1:0] cnt;
  logic [SIZE_W-1:0] dst_m1_q;
  logic [INC_W-1:0]  inc_q;
  logic              busy;

  always_comb begin
    emit    = busy && !line_start;
    is_last = emit && (cnt == dst_m1_q);
    acc_int = acc[ACC_W-1:FRAC_W];
    acc_ph  = acc[FRAC_W-1 -: PHASE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      cnt      <= '0;
      dst_m1_q <= '0;
      inc_q    <= '0;
      shift_q  <= '0;
      busy     <= 1'b0;
      size_err <= 1'b0;
    end else if (line_start) begin
      cnt <= '0;
      if (cfg_bad) begin
        busy     <= 1'b0;
        size_err <= 1'b1;
      end else begin
        busy     <= 1'b1;
        size_err <= 1'b0;
        acc      <= {start_ofs, {FRAC_W{1'b0}}};
        inc_q    <= step_inc;
        shift_q  <= shift_in;
        dst_m1_q <= dst_size - 1'b1;
      end
    end else if (busy) begin
      acc <= acc + ACC_W'(inc_q);
      cnt <= cnt + 1'b1;
      if (cnt == dst_m1_q) busy <= 1'b0;
    end
  end

  // R2: the pixel counter never runs past the captured destination count
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= dst_m1_q))
    else $error("counter beyond destination size");

  // R7: an error state never coexists with an active line
  assert_err_idle_R7: assert property (@(posedge clk) disable iff (rst)
    size_err |-> !busy)
    else $error("active line while error flagged");

endmodule

// File: rtl/lsg_out_stage.sv
module lsg_out_stage #(
  parameter int IDX_W   = 16,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               emit,
  input  logic               is_last,
  input  logic [IDX_W-1:0]   acc_int,
  input  logic [PHASE_W-1:0] acc_ph,
  input  logic [1:0]         shift,
  output logic               out_valid,
  output logic [IDX_W-1:0]   src_index,
  output logic [PHASE_W-1:0] phase,
  output logic               line_done
);

  logic [IDX_W-1:0] idx_scaled;
  logic             last_q;

  always_comb idx_scaled = acc_int << shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      src_index <= '0;
      phase     <= '0;
      last_q    <= 1'b0;
      line_done <= 1'b0;
    end else begin
      out_valid <= emit;
      last_q    <= is_last;
      line_done <= last_q;
      if (emit) begin
        src_index <= idx_scaled;
        phase     <= acc_ph;
      end
    end
  end

  // R3: done comes right after a valid sample and never overlaps one
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    line_done |-> (!out_valid && $past(out_valid)))
    else $error("done pulse misplaced");

  // R3: done is a single-cycle pulse
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    line_done |=> !line_done)
    else $error("done pulse longer than one cycle");

endmodule

// File: rtl/line_step_gen.sv
module line_step_gen #(
  parameter int SIZE_W  = 16,
  parameter int FRAC_W  = 21,
  parameter int IDX_W   = 16,
  parameter int INC_W   = 32,
  parameter int PHASE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line_start,
  input  logic [INC_W-1:0]    step_inc,
  input  logic [1:0]          dec_code,
  input  logic [2*SIZE_W-1:0] size_word,
  input  logic [IDX_W-1:0]    start_ofs,
  output logic                out_valid,
  output logic [IDX_W-1:0]    src_index,
  output logic [PHASE_W-1:0]  phase,
  output logic                line_done,
  output logic                size_err
);

  logic [SIZE_W-1:0]  dst_size;
  logic [1:0]         shift_cfg;
  logic [1:0]         shift_q;
  logic               cfg_bad;
  logic [IDX_W-1:0]   acc_int;
  logic [PHASE_W-1:0] acc_ph;
  logic               emit;
  logic               is_last;

  lsg_cfg_check #(.SIZE_W(SIZE_W)) u_cfg (
    .size_word (size_word),
    .dec_code  (dec_code),
    .dst_size  (dst_size),
    .shift     (shift_cfg),
    .cfg_bad   (cfg_bad)
  );

  lsg_accum #(
    .SIZE_W(SIZE_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W),
    .INC_W(INC_W), .PHASE_W(PHASE_W)
  ) u_acc (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .step_inc   (step_inc),
    .start_ofs  (start_ofs),
    .dst_size   (dst_size),
    .shift_in   (shift_cfg),
    .cfg_bad    (cfg_bad),
    .acc_int    (acc_int),
    .acc_ph     (acc_ph),
    .shift_q    (shift_q),
    .emit       (emit),
    .is_last    (is_last),
    .size_err   (size_err)
  );

  lsg_out_stage #(.IDX_W(IDX_W), .PHASE_W(PHASE_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .emit      (emit),
    .is_last   (is_last),
    .acc_int   (acc_int),
    .acc_ph    (acc_ph),
    .shift     (shift_q),
    .out_valid (out_valid),
    .src_index (src_index),
    .phase     (phase),
    .line_done (line_done)
  );

  // R7: an error flag keeps the sample stream silent
  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    size_err |-> !out_valid)
    else $error("sample emitted while error flagged");

  // R2: a burst of samples only starts two edges after a line start
  assert_first_after_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(line_start, 2))
    else $error("samples began without a line start");

endmodule

// File: tb/sim_line_step_gen.sv
module sim_line_step_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic        is_done;
    logic [15:0] idx;
    logic [3:0]  ph;
  } exp_t;

  logic        clk;
  logic        rst;
  logic        line_start;
  logic [31:0] step_inc;
  logic [1:0]  dec_code;
  logic [31:0] size_word;
  logic [15:0] start_ofs;
  logic        out_valid;
  logic [15:0] src_index;
  logic [3:0]  phase;
  logic        line_done;
  logic        size_err;

  int   total;
  int   bad;
  bit   finished;
  exp_t q[$];

  line_step_gen u0 (
    .clk(clk), .rst(rst), .line_start(line_start), .step_inc(step_inc),
    .dec_code(dec_code), .size_word(size_word), .start_ofs(start_ofs),
    .out_valid(out_valid), .src_index(src_index), .phase(phase),
    .line_done(line_done), .size_err(size_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic longint calc_inc(input int src, input int dst, input int code);
    longint eff;
    eff = longint'(src) >> code;
    return ((eff << 21) + longint'(dst) - 1) / longint'(dst);
  endfunction

  // start a line at the current negedge and queue what it should produce
  task automatic launch(input longint inc, input int code, input int src,
                        input int dst, input int ofs, input int npix,
                        input bit with_done);
    exp_t e;
    longint p;
    step_inc   = inc[31:0];
    dec_code   = code[1:0];
    size_word  = {dst[15:0], src[15:0]};
    start_ofs  = ofs[15:0];
    line_start = 1'b1;
    for (int k = 0; k < npix; k++) begin
      p         = (longint'(ofs) << 21) + longint'(k) * inc;
      e.is_done = 1'b0;
      e.idx     = 16'(((p >> 21) & 64'hFFFF) << code);
      e.ph      = 4'((p >> 17) & 64'hF);
      q.push_back(e);
    end
    if (with_done) begin
      e = '0;
      e.is_done = 1'b1;
      q.push_back(e);
    end
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic drain(input int n, input string req);
    repeat (n) @(negedge clk);
    check(q.size() == 0, req, "expected items left in queue", q.size(), 0);
    q.delete();
  endtask

  task automatic monitor();
    exp_t e;
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (q.size() == 0) check(0, "R2", "unexpected sample", 1, 0);
        else begin
          e = q.pop_front();
          check(!e.is_done, "R3", "sample where done expected", 1, 0);
          check(src_index == e.idx, "R4/R5", "src_index", src_index, e.idx);
          check(phase == e.ph, "R4", "phase", phase, e.ph);
        end
      end
      if (line_done) begin
        if (q.size() == 0) check(0, "R3", "unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          check(e.is_done, "R3", "done where sample expected", 1, 0);
        end
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0;
    rst = 1'b1; line_start = 1'b0;
    step_inc = '0; dec_code = '0; size_word = '0; start_ofs = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(line_done == 0, "R1", "line_done after reset", line_done, 0);
    check(size_err == 0, "R1", "size_err after reset", size_err, 0);
    fork monitor(); join_none

    // R2 R4 R5: enlargement, no decimation
    launch(calc_inc(10, 16, 0), 0, 10, 16, 3, 16, 1);
    drain(20, "R2");
    // R5: halving with decimation by 2
    launch(calc_inc(40, 16, 1), 1, 40, 16, 0, 16, 1);
    drain(20, "R5");
    // R5: half to quarter with decimation by 4, rounded-up increment
    launch(calc_inc(40, 6, 2), 2, 40, 6, 5, 6, 1);
    drain(10, "R5");
    // R9: offset near top of range wraps
    launch(calc_inc(8, 12, 0), 0, 8, 12, 65530, 12, 1);
    drain(16, "R9");

    // R7: zero destination size
    launch(calc_inc(8, 8, 0), 0, 8, 0, 0, 0, 0);
    drain(8, "R7");
    check(size_err == 1, "R7", "size_err with zero dst", size_err, 1);
    // R7: zero source size
    launch(1 << 21, 0, 0, 8, 0, 0, 0);
    drain(8, "R7");
    check(size_err == 1, "R7", "size_err with zero src", size_err, 1);
    // R7: clean start clears the flag
    launch(calc_inc(4, 4, 0), 0, 4, 4, 1, 4, 1);
    check(size_err == 0, "R7", "size_err cleared", size_err, 0);
    drain(8, "R7");
    // R6: invalid decimation code
    launch(1 << 21, 3, 8, 8, 0, 0, 0);
    drain(8, "R6");
    check(size_err == 1, "R6", "size_err with code 11", size_err, 1);

    // R8: configuration changes mid-line are ignored
    launch(calc_inc(6, 9, 0), 0, 6, 9, 2, 9, 1);
    step_inc = 32'h0123_4567; dec_code = 2'b10;
    size_word = {16'd40, 16'd5}; start_ofs = 16'd900;
    drain(14, "R8");

    // R10: restart abandons the running line after 5 samples
    launch(calc_inc(20, 20, 0), 0, 20, 20, 0, 5, 0);
    repeat (5) @(negedge clk);
    launch(calc_inc(12, 7, 1), 1, 12, 7, 4, 7, 1);
    drain(12, "R10");

    // R11: restart coincident with the done pulse
    launch(calc_inc(6, 6, 0), 0, 6, 6, 10, 6, 1);
    repeat (6) @(negedge clk);
    launch(calc_inc(5, 8, 0), 0, 5, 8, 0, 8, 1);
    drain(12, "R11");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule